// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous Static Memory

This block is a synchronous static memory organised as words of four 9-bit byte lanes (36 bits). Every command input (chip select, global write enable, per-lane write enables and address) is captured on the rising clock edge. Read data is loaded into an output register before it reaches the outputs. Write data follows its command by one cycle (late write). The array update is then carried out internally one edge later, with no further involvement from the bus.

The shared data bus is split into `wdata`, `rdata` and a driver enable `drive_en`. The asynchronous active-low `oe_n` and the asynchronous active-high `sleep` control the driver enable directly. While `sleep` is high, sampled commands are discarded. A read directly followed by a write leaves no turnaround cycle on the bus. The block flags that case on `proto_err` and keeps its driver off during the conflicting write-data cycle. The full-size part uses `ADDR_W = 18` (262,144 words). The default parameter is smaller so that the model stays light.

Top module: `lw_sram`

## Requirements
- R1: A write command, followed on the next edge by its data, stores the full 36-bit word. A later read of that address returns it, with lane a = bits 8:0, b = 17:9, c = 26:18 and d = 35:27.
- R2: `lane_wr_n[i]` is active low per lane (index 0 = lane a … 3 = lane d). Only lanes whose enable was low at the command edge are updated, and the other lanes keep their stored value.
- R3: A read command sampled at edge n has its data on `rdata` and `drive_en` high after edge n+1, provided that `oe_n` is low, `sleep` is low and no write-data cycle is in progress.
- R4: Write data is taken from `wdata` at the edge after the write command. The value on `wdata` at the command edge itself has no effect.
- R5: A read issued on the edge right after a write to the same address returns the new data, merged lane by lane with the older stored word.
- R6: `oe_n` high forces `drive_en` low at once, without waiting for a clock edge.
- R7: While `sleep` is high, sampled commands are ignored (a write leaves memory unchanged) and `drive_en` is low at once.
- R8: With `sel_n` high, no array access occurs (a write is discarded). `drive_en` is low once the read pipeline has drained, from the second edge after the last read.
- R9: A read at edge n followed by a write at edge n+1 raises `proto_err` for the cycle after edge n+1 and holds `drive_en` low in that cycle. The write still completes.
- R10: When one idle cycle separates a read from a following write, `proto_err` stays low and the read data is driven.
- R11: During reset, `drive_en` and `proto_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Chip select, active low, sampled |
| wr_n | input | 1 | Global write enable, active low, sampled (high = read) |
| lane_wr_n | input | 4 | Per-lane write enables, active low, sampled |
| addr | input | ADDR_W | Word address, sampled |
| wdata | input | 36 | Write data, sampled one edge after the write command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| rdata | output | 36 | Registered read data |
| drive_en | output | 1 | Three-state driver enable for the data bus |
| proto_err | output | 1 | Read-to-write turnaround violation flag |

## Verification
On every cycle the assertions check the following: the driver is off while `oe_n` or `sleep` is high or while `proto_err` is set, a back-to-back read then write always raises `proto_err`, the driver turns on two edges after an accepted read, and it turns off after deselected cycles. Only the bench scenarios can show data correctness. These include lane-masked writes, the forwarded and merged value on a read right after a write, and the fact that a write issued during sleep or deselect leaves the stored word untouched. They also show that a write flagged as a turnaround error still lands in the array.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
// Command register, late-write pending stage and turnaround check.
module lw_cmd_stage
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    sleep,
  output lw_op_e                  cur_op,
  output logic [ADDR_W-1:0]       cur_addr,
  output logic                    pend_vld,
  output logic [ADDR_W-1:0]       pend_addr,
  output logic [LANES-1:0]        pend_mask,
  output logic [LANES*LANE_W-1:0] pend_data,
  output logic                    proto_err
);
  localparam int DATA_W = LANES * LANE_W;

  lw_op_e              op_q, op_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [LANES-1:0]    mask_q, mask_d;
  logic                pvld_q, pvld_d;
  logic [ADDR_W-1:0]   paddr_q, paddr_d;
  logic [LANES-1:0]    pmask_q, pmask_d;
  logic [DATA_W-1:0]   pdata_q, pdata_d;
  logic                err_q, err_d;
  logic                cmd_en, data_en;

  always_comb begin
    if (sel_n || sleep) op_d = OP_NONE;
    else if (wr_n)      op_d = OP_READ;
    else                op_d = OP_WRITE;
    cmd_en  = (op_d != OP_NONE);
    data_en = (op_q == OP_WRITE);
    addr_d  = cmd_en  ? addr       : addr_q;
    mask_d  = cmd_en  ? ~lane_wr_n : mask_q;
    pvld_d  = data_en;
    paddr_d = data_en ? addr_q     : paddr_q;
    pmask_d = data_en ? mask_q     : pmask_q;
    pdata_d = data_en ? wdata      : pdata_q;
    err_d   = (op_q == OP_READ) && (op_d == OP_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      addr_q  <= '0;
      mask_q  <= '0;
      pvld_q  <= 1'b0;
      paddr_q <= '0;
      pmask_q <= '0;
      pdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      op_q    <= op_d;
      addr_q  <= addr_d;
      mask_q  <= mask_d;
      pvld_q  <= pvld_d;
      paddr_q <= paddr_d;
      pmask_q <= pmask_d;
      pdata_q <= pdata_d;
      err_q   <= err_d;
    end
  end

  assign cur_op    = op_q;
  assign cur_addr  = addr_q;
  assign pend_vld  = pvld_q;
  assign pend_addr = paddr_q;
  assign pend_mask = pmask_q;
  assign pend_data = pdata_q;
  assign proto_err = err_q;
endmodule

// File: rtl/lw_array.sv
// Storage split into one bank per byte lane so each lane writes independently.
module lw_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wmask,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wmask[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/lw_out_stage.sv
// Forwarding merge, output register and driver enable.
module lw_out_stage #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_go,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] arr_data,
  input  logic                    pend_vld,
  input  logic [ADDR_W-1:0]       pend_addr,
  input  logic [LANES-1:0]        pend_mask,
  input  logic [LANES*LANE_W-1:0] pend_data,
  input  logic                    wr_busy,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    drive_en
);
  localparam int DATA_W = LANES * LANE_W;

  logic              fwd_hit;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvld_q, rvld_d;

  assign fwd_hit = pend_vld && (pend_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit && pend_mask[g]) ?
        pend_data[g*LANE_W +: LANE_W] : arr_data[g*LANE_W +: LANE_W];
  end

  always_comb begin
    rvld_d  = rd_go;
    rdata_d = rd_go ? merged : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      rvld_q  <= rvld_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata    = rdata_q;
  assign drive_en = !oe_n && !sleep && rvld_q && !wr_busy;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    drive_en,
  output logic                    proto_err
);
  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rst_pipe;
  logic              rst_n_i;
  lw_op_e            cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_mask;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] arr_data;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n_i), .sel_n(sel_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr), .wdata(wdata), .sleep(sleep),
    .cur_op(cur_op), .cur_addr(cur_addr), .pend_vld(pend_vld),
    .pend_addr(pend_addr), .pend_mask(pend_mask), .pend_data(pend_data),
    .proto_err(proto_err)
  );

  lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .we(pend_vld), .waddr(pend_addr), .wmask(pend_mask),
    .wdata(pend_data), .raddr(cur_addr), .rdata(arr_data)
  );

  lw_out_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk(clk), .rst_n(rst_n_i), .rd_go(cur_op == OP_READ),
    .rd_addr(cur_addr), .arr_data(arr_data), .pend_vld(pend_vld),
    .pend_addr(pend_addr), .pend_mask(pend_mask), .pend_data(pend_data),
    .wr_busy(cur_op == OP_WRITE), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .drive_en(drive_en)
  );
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic wr_n,
  input logic sleep,
  input logic oe_n,
  input logic drive_en,
  input logic proto_err
);
  assert_oe_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive_en);

  assert_sleep_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !drive_en);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || sleep) |=> ##1 !drive_en);

  assert_err_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !drive_en);

  assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && wr_n && !sleep) ##1 (!sel_n && !wr_n && !sleep) |=> proto_err);

  assert_read_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && wr_n && !sleep) |=> ##1 (oe_n || sleep || proto_err || drive_en));
endmodule

bind lw_sram lw_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .sleep(sleep),
  .oe_n(oe_n), .drive_en(drive_en), .proto_err(proto_err)
);

// File: tb/tb_lw_sram.sv
module tb_lw_sram;
  logic        clk;
  logic        rst_n;
  logic        sel_n, wr_n, oe_n, sleep;
  logic [3:0]  lane_wr_n;
  logic [7:0]  addr;
  logic [35:0] wdata;
  logic [35:0] rdata;
  logic        drive_en, proto_err;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  lw_sram dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .sleep(sleep), .rdata(rdata), .drive_en(drive_en), .proto_err(proto_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        s;
    logic        w;
    logic [3:0]  ln;
    logic [7:0]  a;
    logic [35:0] wd;
    logic        sl;
    logic        chk;
    logic [35:0] exp;
  } vec_t;

  localparam logic [7:0] AA = 8'h05;
  localparam logic [7:0] BB = 8'h09;

  // each row: inputs for one edge; chk compares the read issued in the row before
  localparam vec_t VECS [23] = '{
    '{1'b0, 1'b0, 4'b0000, AA,    36'hDEADBEEF0, 1'b0, 1'b0, 36'h0},          // R4 junk at cmd edge
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h123456789, 1'b0, 1'b0, 36'h0},          // R1 data
    '{1'b0, 1'b1, 4'b0000, AA,    36'h0,         1'b0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h0,         1'b0, 1'b1, 36'h123456789},  // R1 R4
    '{1'b0, 1'b0, 4'b1010, AA,    36'h0AAAAAAAA, 1'b0, 1'b0, 36'h0},          // lanes a,c
    '{1'b0, 1'b1, 4'b0000, AA,    36'hFFFFFFFFF, 1'b0, 1'b0, 36'h0},          // R5 read now
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h0,         1'b0, 1'b1, 36'h127FD67FF},  // R5 merged
    '{1'b0, 1'b1, 4'b0000, AA,    36'h0,         1'b0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h0,         1'b0, 1'b1, 36'h127FD67FF},  // R2 stored
    '{1'b0, 1'b0, 4'b0000, BB,    36'h0,         1'b0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'hABCDE0123, 1'b0, 1'b0, 36'h0},
    '{1'b0, 1'b0, 4'b0111, BB,    36'h0,         1'b0, 1'b0, 36'h0},          // lane d only
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h000000000, 1'b0, 1'b0, 36'h0},
    '{1'b0, 1'b1, 4'b0000, BB,    36'h0,         1'b0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h0,         1'b0, 1'b1, 36'h004DE0123},  // R2 lane d
    '{1'b0, 1'b0, 4'b0000, AA,    36'h0,         1'b1, 1'b0, 36'h0},          // R7 write in sleep
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h000000000, 1'b0, 1'b0, 36'h0},
    '{1'b0, 1'b1, 4'b0000, AA,    36'h0,         1'b0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h0,         1'b0, 1'b1, 36'h127FD67FF},  // R7 unchanged
    '{1'b1, 1'b0, 4'b0000, BB,    36'h0,         1'b0, 1'b0, 36'h0},          // R8 deselected write
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h111111111, 1'b0, 1'b0, 36'h0},
    '{1'b0, 1'b1, 4'b0000, BB,    36'h0,         1'b0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 4'b0000, 8'h00, 36'h0,         1'b0, 1'b1, 36'h004DE0123}   // R8 unchanged
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [3:0] ln,
                      input logic [7:0] a, input logic [35:0] d, input logic sl);
    sel_n = s; wr_n = w; lane_wr_n = ln; addr = a; wdata = d; sleep = sl;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; lane_wr_n = 4'hF;
    addr = '0; wdata = '0; oe_n = 1'b0; sleep = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 drive_en in reset", {35'd0, drive_en}, 36'd0);
    check("R11 proto_err in reset", {35'd0, proto_err}, 36'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 23; i++) begin
      step(VECS[i].s, VECS[i].w, VECS[i].ln, VECS[i].a, VECS[i].wd, VECS[i].sl);
      if (VECS[i].chk) begin
        check($sformatf("R1/R2/R5 row %0d rdata", i), rdata, VECS[i].exp);
        check($sformatf("R3 row %0d drive_en", i), {35'd0, drive_en}, 36'd1);
      end
    end

    // R3 R6 R7 R8: driver control on a valid read
    step(1'b0, 1'b1, 4'h0, AA, 36'h0, 1'b0);
    step(1'b1, 1'b1, 4'h0, 8'h00, 36'h0, 1'b0);
    check("R3 drive after read", {35'd0, drive_en}, 36'd1);
    oe_n = 1'b1; #1;
    check("R6 oe_n async off", {35'd0, drive_en}, 36'd0);
    oe_n = 1'b0; #1;
    check("R6 oe_n back on", {35'd0, drive_en}, 36'd1);
    sleep = 1'b1; #1;
    check("R7 sleep async off", {35'd0, drive_en}, 36'd0);
    sleep = 1'b0; #1;
    step(1'b1, 1'b1, 4'h0, 8'h00, 36'h0, 1'b0);
    check("R8 drained", {35'd0, drive_en}, 36'd0);

    // R9: read directly followed by write
    step(1'b0, 1'b1, 4'h0, AA, 36'h0, 1'b0);
    step(1'b0, 1'b0, 4'h0, BB, 36'h0, 1'b0);
    check("R9 proto_err set", {35'd0, proto_err}, 36'd1);
    check("R9 no drive", {35'd0, drive_en}, 36'd0);
    step(1'b1, 1'b1, 4'h0, 8'h00, 36'h555555555, 1'b0);
    check("R9 proto_err clears", {35'd0, proto_err}, 36'd0);
    step(1'b0, 1'b1, 4'h0, BB, 36'h0, 1'b0);
    step(1'b1, 1'b1, 4'h0, 8'h00, 36'h0, 1'b0);
    check("R9 write completed", rdata, 36'h555555555);

    // R10: read, idle, write
    step(1'b0, 1'b1, 4'h0, AA, 36'h0, 1'b0);
    step(1'b1, 1'b1, 4'h0, 8'h00, 36'h0, 1'b0);
    check("R10 read data", rdata, 36'h127FD67FF);
    check("R10 no error on idle", {35'd0, proto_err}, 36'd0);
    step(1'b0, 1'b0, 4'h0, BB, 36'h0, 1'b0);
    check("R10 no error on write", {35'd0, proto_err}, 36'd0);
    step(1'b1, 1'b1, 4'h0, 8'h00, 36'h0F0F0F0F0, 1'b0);
    step(1'b0, 1'b1, 4'h0, BB, 36'h0, 1'b0);
    step(1'b1, 1'b1, 4'h0, 8'h00, 36'h0, 1'b0);
    check("R10 write data", rdata, 36'h0F0F0F0F0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule